// File: doc/BRIEF.md
# Strided Window Vector ALU

This engine post-processes lane-wise vector data held in an on-chip buffer. It walks an output tile in raster order. For every output element it reads a rectangular window of input entries, folds them lane by lane with one binary operation, and writes the result vector to an output buffer. One 120-bit configuration word describes a whole pass, so one datapath covers three jobs. Rectification is a maximum against an immediate zero over a 1×1 window. Pooling is a maximum over an R×S window. Batch-norm style accumulation is a wrapping sum.

The configuration word gives three address strides: one per output pixel, one per window row and one per window column. Overlapping windows, spaced pooling and dense elementwise passes all use the same address walk. Reads go to a synchronous memory with one cycle of latency. The engine issues one read per cycle with no gaps. A write carries one full vector of `LANES` signed lanes. Lanes beyond the configured active count are written as zero.

A start pulse while idle latches the word. A single-cycle done pulse follows the last write.

Top module: `win_vec_alu`

## Requirements
- R1: The configuration word is decoded with these bit positions:
  - opcode [119:118]
  - input base [117:103]
  - output base [102:88]
  - output rows [87:80] and output columns [79:72]
  - window rows [71:68] and window columns [67:64]
  - pixel stride [63:56], row stride [55:48] and column stride [47:40]
  - active-lane count [39:32]
  - immediate enable [31] and immediate value [30:23]
  - bits [22:0] are spare and have no effect.
- R2: A start pulse while idle latches the word. A start pulse while a pass is in progress is ignored and leaves the pass unchanged.
- R3: Read addresses follow `in_base + k*pix_stride + r*row_stride + c*col_stride` modulo 2^15.
  - k = row*out_cols + col is the raster index of the output.
  - The window column c is the innermost loop, then the window row r, then k.
  - One read is issued per cycle, with no gaps, from the first read to the last.
- R4: Exactly one write is made per output, in raster order, at address `out_base + k` modulo 2^15.
- R5: Opcodes 0 and 3 both fold the window taps with a signed per-lane maximum, starting from the first tap.
- R6: Opcode 1 folds the window taps with a per-lane sum that wraps modulo 2^DW.
- R7: Opcode 2 folds the window taps with a signed per-lane minimum.
- R8: With the immediate enable set, each lane result becomes op(fold, imm), with the 8-bit immediate sign-extended and applied to every lane. Opcode 0 with a 1×1 window and an immediate of 0 yields a rectified output.
- R9: Lane i is written as zero when i ≥ the active-lane count. A count of LANES or more leaves every lane active.
- R10: A window row or column count of 0 behaves as 1.
- R11: With output rows or columns equal to 0, no reads or writes occur, and done pulses in the cycle after the start cycle.
- R12: Timing of a pass:
  - The first read appears in the cycle after the start cycle.
  - An output's write appears two cycles after its last window read.
  - Done is high for exactly one cycle, the cycle after the final write.
- R13: During and right after reset, rd_en, wr_en and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a pass when the engine is idle |
| cfg_word | input | 120 | Configuration word, sampled with an accepted start |
| rd_en | output | 1 | Read strobe to the input memory |
| rd_addr | output | 15 | Input memory address |
| rd_data | input | LANES*DW | Input vector, valid one cycle after rd_en |
| wr_en | output | 1 | Write strobe to the output memory |
| wr_addr | output | 15 | Output memory address |
| wr_data | output | LANES*DW | Result vector, lane i at bits [i*DW +: DW] |
| done | output | 1 | One-cycle pulse ending a pass |

## Verification
The in-line properties watch four things every cycle:
- the column step between successive taps of a window;
- that reads and writes stay inside the busy window and that each write follows a read two cycles earlier;
- that inactive lanes are zero on every write and that done is a single-cycle pulse;
- that the latched configuration stays frozen while a pass runs, so a stray start cannot alter it.

The fold arithmetic itself, the full three-level address sequence, and the absolute cycle positions of the first read, the last write and done are shown only by the bench. Its sweeps cover every opcode code against every window shape up to 3×3, plus the following cases:
- rectification;
- biased sums with a negative immediate;
- extreme lane counts;
- zero-size windows and tiles;
- address wrap at the top of the 15-bit space;
- a start pulse mid-pass;
- a word whose spare bits are all ones.

// File: rtl/wva_pkg.sv
package wva_pkg;
  localparam int OPC_W  = 2;
  localparam int ADDR_W = 15;
  localparam int DIM_W  = 8;
  localparam int WIN_W  = 4;
  localparam int STR_W  = 8;
  localparam int CNT_W  = 8;
  localparam int IMM_W  = 8;
  localparam int PAD_W  = 23;
  localparam int WORD_W = OPC_W + 2*ADDR_W + 2*DIM_W + 2*WIN_W + 3*STR_W
                        + CNT_W + 1 + IMM_W + PAD_W;

  typedef enum logic [OPC_W-1:0] {
    OP_MAX     = 2'd0,
    OP_ADD     = 2'd1,
    OP_MIN     = 2'd2,
    OP_MAX_ALT = 2'd3
  } op_e;

  // Field order is fixed: the upstream issuer packs words this way.
  typedef struct packed {
    op_e                 opc;
    logic [ADDR_W-1:0]   src_base;
    logic [ADDR_W-1:0]   dst_base;
    logic [DIM_W-1:0]    out_rows;
    logic [DIM_W-1:0]    out_cols;
    logic [WIN_W-1:0]    win_rows;
    logic [WIN_W-1:0]    win_cols;
    logic [STR_W-1:0]    step_pix;
    logic [STR_W-1:0]    step_row;
    logic [STR_W-1:0]    step_col;
    logic [CNT_W-1:0]    lane_cnt;
    logic                imm_en;
    logic [IMM_W-1:0]    imm_val;
    logic [PAD_W-1:0]    spare;
  } cfg_t;
endpackage

// File: rtl/wva_lane_op.sv
module wva_lane_op
  import wva_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 8
) (
  input  op_e                   opc,
  input  logic [LANES*DW-1:0]   a,
  input  logic [LANES*DW-1:0]   b,
  output logic [LANES*DW-1:0]   y
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [DW-1:0] la, lb, ly;
    assign la = a[g*DW +: DW];
    assign lb = b[g*DW +: DW];
    always_comb begin
      case (opc)
        OP_ADD:  ly = la + lb;
        OP_MIN:  ly = (la < lb) ? la : lb;
        default: ly = (la > lb) ? la : lb;
      endcase
    end
    assign y[g*DW +: DW] = ly;
  end
endmodule

// File: rtl/wva_addr_gen.sv
module wva_addr_gen
  import wva_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  cfg_t              cfg,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tap_first,
  output logic              tap_last,
  output logic              pix_last,
  output logic [ADDR_W-1:0] dst_addr
);
  localparam int PIX_W = 2*DIM_W;

  logic [WIN_W-1:0]  win_r_eff, win_c_eff, r_cnt, c_cnt;
  logic [PIX_W-1:0]  n_pix, pix_cnt;
  logic [ADDR_W-1:0] pix_ptr, row_ptr, pix_nx, row_nx;
  logic              empty, one_tap, row_end, col_end;
  logic              unused_fields;

  assign unused_fields = ^{cfg.opc, cfg.lane_cnt, cfg.imm_en, cfg.imm_val, cfg.spare};

  always_comb begin
    win_r_eff = (cfg.win_rows == '0) ? WIN_W'(1) : cfg.win_rows;
    win_c_eff = (cfg.win_cols == '0) ? WIN_W'(1) : cfg.win_cols;
    n_pix     = PIX_W'(cfg.out_rows) * PIX_W'(cfg.out_cols);
    empty     = (n_pix == '0);
    one_tap   = (win_r_eff == WIN_W'(1)) && (win_c_eff == WIN_W'(1));
    row_end   = (r_cnt == win_r_eff - WIN_W'(1));
    col_end   = (c_cnt == win_c_eff - WIN_W'(1));
    pix_nx    = pix_ptr + ADDR_W'(cfg.step_pix);
    row_nx    = row_ptr + ADDR_W'(cfg.step_row);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      pix_ptr   <= '0;
      row_ptr   <= '0;
      r_cnt     <= '0;
      c_cnt     <= '0;
      pix_cnt   <= '0;
      dst_addr  <= '0;
      tap_first <= 1'b0;
      tap_last  <= 1'b0;
      pix_last  <= 1'b0;
    end else if (go) begin
      if (!empty) begin
        rd_en     <= 1'b1;
        rd_addr   <= cfg.src_base;
        pix_ptr   <= cfg.src_base;
        row_ptr   <= cfg.src_base;
        r_cnt     <= '0;
        c_cnt     <= '0;
        pix_cnt   <= '0;
        dst_addr  <= cfg.dst_base;
        tap_first <= 1'b1;
        tap_last  <= one_tap;
        pix_last  <= (n_pix == PIX_W'(1));
      end
    end else if (rd_en) begin
      if (tap_last && pix_last) begin
        rd_en     <= 1'b0;
        tap_first <= 1'b0;
        tap_last  <= 1'b0;
        pix_last  <= 1'b0;
      end else if (!col_end) begin
        c_cnt     <= c_cnt + WIN_W'(1);
        rd_addr   <= rd_addr + ADDR_W'(cfg.step_col);
        tap_first <= 1'b0;
        tap_last  <= row_end && (c_cnt + WIN_W'(1) == win_c_eff - WIN_W'(1));
      end else if (!row_end) begin
        r_cnt     <= r_cnt + WIN_W'(1);
        c_cnt     <= '0;
        row_ptr   <= row_nx;
        rd_addr   <= row_nx;
        tap_first <= 1'b0;
        tap_last  <= (r_cnt + WIN_W'(1) == win_r_eff - WIN_W'(1)) && (win_c_eff == WIN_W'(1));
      end else begin
        pix_cnt   <= pix_cnt + PIX_W'(1);
        r_cnt     <= '0;
        c_cnt     <= '0;
        pix_ptr   <= pix_nx;
        row_ptr   <= pix_nx;
        rd_addr   <= pix_nx;
        dst_addr  <= dst_addr + ADDR_W'(1);
        tap_first <= 1'b1;
        tap_last  <= one_tap;
        pix_last  <= (pix_cnt + PIX_W'(1) == n_pix - PIX_W'(1));
      end
    end
  end

  // R3: consecutive taps inside one window row are one column stride apart
  a_r3_column_step: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en) && !tap_first && c_cnt != '0)
      |-> rd_addr == $past(rd_addr) + ADDR_W'(cfg.step_col));

  // R3: a window never starts mid-row
  a_r3_first_tap_origin: assert property (@(posedge clk) disable iff (rst)
    (rd_en && tap_first) |-> (r_cnt == '0 && c_cnt == '0));
endmodule

// File: rtl/wva_fold_stage.sv
module wva_fold_stage
  import wva_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [LANES*DW-1:0] rd_data,
  input  logic                tap_first,
  input  logic                tap_last,
  input  logic                pix_last,
  input  logic [ADDR_W-1:0]   dst_addr,
  input  op_e                 opc,
  input  logic                imm_en,
  input  logic [IMM_W-1:0]    imm_val,
  input  logic [CNT_W-1:0]    lane_cnt,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [LANES*DW-1:0] wr_data,
  output logic                wr_last
);
  localparam int VW = LANES*DW;

  logic              valid_q, first_q, last_q, plast_q;
  logic [ADDR_W-1:0] dst_q;
  logic [VW-1:0]     acc, fold_y, folded, imm_vec, imm_y, result, masked;
  logic signed [DW-1:0] imm_x;

  assign imm_x = DW'($signed(imm_val));

  for (genvar g = 0; g < LANES; g++) begin : g_imm
    assign imm_vec[g*DW +: DW] = imm_x;
  end

  wva_lane_op #(.LANES(LANES), .DW(DW)) u_fold (
    .opc(opc), .a(acc), .b(rd_data), .y(fold_y));

  assign folded = first_q ? rd_data : fold_y;

  wva_lane_op #(.LANES(LANES), .DW(DW)) u_imm (
    .opc(opc), .a(folded), .b(imm_vec), .y(imm_y));

  assign result = imm_en ? imm_y : folded;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign masked[g*DW +: DW] = (32'(g) < 32'(lane_cnt)) ? result[g*DW +: DW] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      plast_q <= 1'b0;
      dst_q   <= '0;
      acc     <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_last <= 1'b0;
    end else begin
      valid_q <= rd_en;
      first_q <= tap_first;
      last_q  <= tap_last;
      plast_q <= pix_last;
      dst_q   <= dst_addr;
      wr_en   <= valid_q && last_q;
      wr_last <= valid_q && last_q && plast_q;
      if (valid_q) begin
        acc <= folded;
        if (last_q) begin
          wr_addr <= dst_q;
          wr_data <= masked;
        end
      end
    end
  end

  // R12: each write is produced by a read issued two cycles earlier
  a_r12_write_after_read: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rd_en, 2));

  // R9: lanes past the active count leave as zero
  for (genvar g = 0; g < LANES; g++) begin : g_chk
    a_r9_idle_lane_zero: assert property (@(posedge clk) disable iff (rst)
      (wr_en && 32'(g) >= 32'(lane_cnt)) |-> wr_data[g*DW +: DW] == '0);
  end
endmodule

// File: rtl/win_vec_alu.sv
module win_vec_alu
  import wva_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [WORD_W-1:0]     cfg_word,
  output logic                  rd_en,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic [LANES*DW-1:0]   rd_data,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [LANES*DW-1:0]   wr_data,
  output logic                  done
);
  cfg_t cfg_in, cfg_q, cfg_cur;
  logic busy, go, empty;
  logic tap_first, tap_last, pix_last, wr_last;
  logic [ADDR_W-1:0] dst_addr;

  assign cfg_in  = cfg_t'(cfg_word);
  assign go      = start && !busy;
  assign empty   = (cfg_in.out_rows == '0) || (cfg_in.out_cols == '0);
  assign cfg_cur = go ? cfg_in : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cfg_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= (wr_en && wr_last) || (go && empty);
      if (go) begin
        busy  <= 1'b1;
        cfg_q <= cfg_in;
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  wva_addr_gen u_agen (
    .clk(clk), .rst(rst), .go(go), .cfg(cfg_cur),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .tap_first(tap_first), .tap_last(tap_last), .pix_last(pix_last),
    .dst_addr(dst_addr));

  wva_fold_stage #(.LANES(LANES), .DW(DW)) u_fold (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data),
    .tap_first(tap_first), .tap_last(tap_last), .pix_last(pix_last),
    .dst_addr(dst_addr), .opc(cfg_q.opc), .imm_en(cfg_q.imm_en),
    .imm_val(cfg_q.imm_val), .lane_cnt(cfg_q.lane_cnt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last));

  // R12: completion is a single-cycle pulse
  a_r12_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: the latched word cannot change while a pass runs
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_q));

  // R4: writes only inside a pass
  a_r4_write_in_pass: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  // R3: reads only inside a pass
  a_r3_read_in_pass: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
endmodule

// File: tb/sim_win_vec_alu.sv
`timescale 1ns/1ps
module sim_win_vec_alu;
  localparam int LN = 4;
  localparam int DW = 8;
  localparam int VW = LN*DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [119:0]  word = '0;
  logic          rd_en, wr_en, done;
  logic [14:0]   rd_addr, wr_addr;
  logic [VW-1:0] rd_data = '0;
  logic [VW-1:0] wr_data;

  always #2.5 clk = ~clk;

  win_vec_alu #(.LANES(LN), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_word(word),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] src_val(input int addr, input int lane);
    return 8'(addr*37 + lane*59 + 11);
  endfunction

  always @(posedge clk)
    if (rd_en)
      for (int l = 0; l < LN; l++) rd_data[l*DW +: DW] <= src_val(int'(rd_addr), l);

  // current pass description
  int c_op, c_ib, c_ob, c_oh, c_ow, c_wh, c_ww, c_sp, c_sr, c_sc, c_ln, c_ie, c_iv;
  logic [22:0] c_pad;
  int whe, wwe;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic signed [7:0] op_f(input int op, input logic signed [7:0] a,
                                             input logic signed [7:0] b);
    case (op)
      1: return a + b;
      2: return (a < b) ? a : b;
      default: return (a > b) ? a : b;
    endcase
  endfunction

  function automatic logic [VW-1:0] expect_out(input int k);
    logic [VW-1:0] res;
    for (int l = 0; l < LN; l++) begin
      logic signed [7:0] acc;
      acc = '0;
      for (int r = 0; r < whe; r++)
        for (int s = 0; s < wwe; s++) begin
          int a;
          a = (c_ib + k*c_sp + r*c_sr + s*c_sc) % 32768;
          if (r == 0 && s == 0) acc = src_val(a, l);
          else acc = op_f(c_op, acc, src_val(a, l));
        end
      if (c_ie != 0) acc = op_f(c_op, acc, 8'(c_iv));
      if (l >= c_ln) acc = '0;
      res[l*DW +: DW] = acc;
    end
    return res;
  endfunction

  // monitor
  bit mon_on = 0;
  int n_rd, n_wr, n_done, first_rd, last_rd, last_wr, done_cyc;
  logic [14:0]   cap_a [64];
  logic [VW-1:0] cap_d [64];

  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_en) begin
        int taps, k, t, ea;
        taps = whe*wwe;
        k = n_rd / taps;
        t = n_rd % taps;
        ea = (c_ib + k*c_sp + (t / wwe)*c_sr + (t % wwe)*c_sc) % 32768;
        check(int'(rd_addr) == ea, "R3", "read address", rd_addr, ea);
        if (first_rd < 0) first_rd = cyc;
        last_rd = cyc;
        n_rd++;
      end
      if (wr_en) begin
        if (n_wr < 64) begin
          cap_a[n_wr] = wr_addr;
          cap_d[n_wr] = wr_data;
        end
        n_wr++;
        last_wr = cyc;
      end
      if (done) begin
        n_done++;
        done_cyc = cyc;
      end
    end
  end

  task automatic do_run(input string dreq, input bit mid_start);
    int st_cyc, w, total;
    whe = (c_wh == 0) ? 1 : c_wh;
    wwe = (c_ww == 0) ? 1 : c_ww;
    total = c_oh*c_ow;
    word = {c_op[1:0], 15'(c_ib), 15'(c_ob), 8'(c_oh), 8'(c_ow), 4'(c_wh), 4'(c_ww),
            8'(c_sp), 8'(c_sr), 8'(c_sc), 8'(c_ln), c_ie[0], 8'(c_iv), c_pad};
    n_rd = 0; n_wr = 0; n_done = 0; first_rd = -1; last_rd = -1; last_wr = -1; done_cyc = -1;
    @(negedge clk);
    start = 1'b1;
    st_cyc = cyc;
    mon_on = 1;
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (2) @(negedge clk);
      word = ~word;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (n_done == 0 && w < 3000) begin
      @(negedge clk);
      w++;
    end
    check(n_done != 0, "R12", "done seen before timeout", n_done, 1);
    repeat (4) @(negedge clk);
    mon_on = 0;
    check(n_done == 1, "R12", "done pulse count", n_done, 1);
    if (total == 0) begin
      check(n_rd == 0, "R11", "reads on empty tile", n_rd, 0);
      check(n_wr == 0, "R11", "writes on empty tile", n_wr, 0);
      check(done_cyc == st_cyc + 1, "R11", "done cycle on empty tile", done_cyc, st_cyc + 1);
    end else begin
      check(n_rd == total*whe*wwe, "R3", "read count", n_rd, total*whe*wwe);
      check(first_rd == st_cyc + 1, "R12", "first read cycle", first_rd, st_cyc + 1);
      check(last_rd - first_rd + 1 == n_rd, "R3", "gap-free reads", last_rd - first_rd + 1, n_rd);
      check(n_wr == total, "R4", "write count", n_wr, total);
      check(last_wr == last_rd + 2, "R12", "last write cycle", last_wr, last_rd + 2);
      check(done_cyc == last_wr + 1, "R12", "done cycle", done_cyc, last_wr + 1);
      for (int k = 0; k < total && k < n_wr && k < 64; k++) begin
        logic [VW-1:0] e;
        e = expect_out(k);
        check(int'(cap_a[k]) == (c_ob + k) % 32768, "R4", "write address",
              cap_a[k], (c_ob + k) % 32768);
        check(cap_d[k] == e, dreq, "write data", cap_d[k], e);
      end
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(input int op, input int ib, input int ob, input int oh, input int ow,
                         input int wh, input int ww, input int sp, input int sr, input int sc,
                         input int ln, input int ie, input int iv);
    c_op = op; c_ib = ib; c_ob = ob; c_oh = oh; c_ow = ow; c_wh = wh; c_ww = ww;
    c_sp = sp; c_sr = sr; c_sc = sc; c_ln = ln; c_ie = ie; c_iv = iv; c_pad = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R13: reset state
    check(rd_en == 1'b0, "R13", "rd_en in reset", rd_en, 0);
    check(wr_en == 1'b0, "R13", "wr_en in reset", wr_en, 0);
    check(done == 1'b0, "R13", "done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    check(rd_en == 1'b0 && wr_en == 1'b0 && done == 1'b0, "R13", "outputs after reset",
          {rd_en, wr_en, done}, 0);

    // R8: rectification (max with immediate 0, 1x1 window)
    set_cfg(0, 10, 100, 3, 4, 1, 1, 1, 1, 1, 4, 1, 0);
    do_run("R8", 0);

    // R5 R6 R7: every opcode code against every window shape up to 3x3
    for (int op = 0; op < 4; op++)
      for (int wh = 1; wh <= 3; wh++)
        for (int ww = 1; ww <= 3; ww++) begin
          set_cfg(op, 20 + op, 200, 2, 2, wh, ww, 3, 7, 1, 3, 0, 0);
          do_run(op == 1 ? "R6" : (op == 2 ? "R7" : "R5"), 0);
        end

    // R8: biased sum with a negative immediate
    set_cfg(1, 40, 300, 2, 3, 2, 1, 2, 5, 1, 4, 1, 8'hFD);
    do_run("R8", 0);
    // R8: min against an immediate
    set_cfg(2, 50, 310, 1, 3, 1, 2, 4, 1, 2, 4, 1, 5);
    do_run("R8", 0);

    // R9: no active lanes, then an oversize count
    set_cfg(0, 60, 320, 2, 2, 2, 2, 2, 6, 1, 0, 0, 0);
    do_run("R9", 0);
    set_cfg(1, 61, 330, 2, 2, 1, 2, 2, 6, 1, 200, 0, 0);
    do_run("R9", 0);

    // R10: zero window dimensions act as 1
    set_cfg(1, 70, 340, 2, 2, 0, 0, 3, 4, 5, 4, 0, 0);
    do_run("R10", 0);
    set_cfg(0, 71, 350, 2, 1, 0, 3, 3, 4, 1, 4, 0, 0);
    do_run("R10", 0);

    // R11: empty tile
    set_cfg(0, 80, 360, 0, 5, 2, 2, 1, 1, 1, 4, 0, 0);
    do_run("R11", 0);
    set_cfg(0, 80, 360, 4, 0, 1, 1, 1, 1, 1, 4, 0, 0);
    do_run("R11", 0);

    // R3 R4: address wrap at the top of the space
    set_cfg(0, 32760, 32766, 2, 2, 2, 2, 3, 4, 1, 4, 0, 0);
    do_run("R3", 0);

    // R2: start pulse mid-pass is ignored
    set_cfg(0, 90, 400, 2, 3, 2, 2, 2, 9, 1, 4, 0, 0);
    do_run("R2", 1);

    // R1: spare bits have no effect
    set_cfg(1, 95, 410, 2, 2, 2, 1, 3, 2, 1, 3, 1, 7);
    c_pad = '1;
    do_run("R1", 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule